// File: doc/BRIEF.md
# Display Event Status and Interrupt Unit

This unit collects single-cycle event pulses from a display controller's raster, DMA and palette logic and holds them in a sticky raw status register. Software reads the raw status, or a masked view filtered by an interrupt enable mask, over a plain register port. It acknowledges events by writing ones to the bits it wants cleared. Writing back exactly the value it read therefore acknowledges the events it saw and keeps any that arrived later.

The enable mask is never written directly. One offset ORs ones into it and another offset removes them, so separate software agents can change their own bits without a read-modify-write. A level interrupt line is high while any enabled event is pending. A write of any value to the end-of-interrupt offset drops the line for one cycle, so a downstream edge-sensitive interrupt controller sees a new edge if events remain pending.

Writes take effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr` and the current register state, with no wait states. The register port has no handshake: every access completes in one cycle and cannot be stalled.

Top module: `disp_evt_irq`

## Requirements
- R1: After reset the raw status and the enable mask are zero, `irq_o` is low, and every offset reads zero.
- R2: The event inputs `evt_i[0]`..`evt_i[5]` (frame done, sync lost, FIFO underflow, palette loaded, end-of-frame 0, end-of-frame 1) set raw status bits 0, 2, 5, 6, 8 and 9 respectively. A bit reads as set from the cycle after its pulse and stays set until software clears it.
- R3: A write to the raw status offset 0x58 or the masked status offset 0x5C clears every status bit whose write-data bit is one and leaves the other bits unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set. Other bits cleared by that write are still cleared.
- R5: A write to offset 0x60 ORs the write data into the enable mask. A write to offset 0x64 clears the enable bits whose write-data bit is one. Reads of either offset return the current enable mask.
- R6: A read of offset 0x5C returns raw status AND enable mask. A read of 0x58 returns raw status.
- R7: `irq_o` is high whenever raw status AND enable mask is nonzero, unless the end-of-interrupt hold of R8 applies. It is low whenever that AND is zero.
- R8: A write of any data to offset 0x68 forces `irq_o` low for exactly the cycle after the write. The line then returns high only if masked status is still nonzero.
- R9: Bits 1, 3, 4, 7 and 10 and above never become set in status or enable, and they read as zero. Writes to any other offset change nothing, and reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event pulses, one per event, ordered as in R2 |
| bus_wr | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
Any error in the sticky status or enable state shows up at `bus_rdata` as soon as the affected offset is addressed, in the same cycle. It reaches `irq_o` in the cycle after the edge that corrupted it. A lost set-versus-clear priority leaves the bit read as zero immediately after the colliding write. A stuck or missing end-of-interrupt hold shows as `irq_o` staying high, or staying low one cycle too long, right after a write to 0x68. The directed cases check each of these at the first cycle where the fault would appear.

// File: rtl/disp_evt_pkg.sv
package disp_evt_pkg;

  localparam int NUM_EVT = 6;
  localparam int STAT_W  = 10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_MASKED,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_EOI
  } reg_sel_e;

  // Status bit position owned by each event input.
  function automatic int unsigned evt_bit(input int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 2;
      2:       return 5;
      3:       return 6;
      4:       return 8;
      default: return 9;
    endcase
  endfunction

  // Bits that can ever hold a one.
  function automatic logic [STAT_W-1:0] impl_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_EVT; i++) begin
      m[evt_bit(i)] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/disp_evt_decode.sv
module disp_evt_decode
  import disp_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFF_RAW    = 8'h58,
  parameter logic [ADDR_W-1:0] OFF_MASKED = 8'h5C,
  parameter logic [ADDR_W-1:0] OFF_EN_SET = 8'h60,
  parameter logic [ADDR_W-1:0] OFF_EN_CLR = 8'h64,
  parameter logic [ADDR_W-1:0] OFF_EOI    = 8'h68
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [STAT_W-1:0] raw_stat,
  input  logic [STAT_W-1:0] masked_stat,
  input  logic [STAT_W-1:0] en_mask,
  output logic              stat_clr_we,
  output logic              en_set_we,
  output logic              en_clr_we,
  output logic              eoi_we,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int PAD_W = DATA_W - STAT_W;

  reg_sel_e          sel;
  logic [STAT_W-1:0] rd_bits;

  always_comb begin
    if      (bus_addr == OFF_RAW)    sel = SEL_RAW;
    else if (bus_addr == OFF_MASKED) sel = SEL_MASKED;
    else if (bus_addr == OFF_EN_SET) sel = SEL_EN_SET;
    else if (bus_addr == OFF_EN_CLR) sel = SEL_EN_CLR;
    else if (bus_addr == OFF_EOI)    sel = SEL_EOI;
    else                             sel = SEL_NONE;
  end

  always_comb begin
    stat_clr_we = bus_wr && (sel == SEL_RAW || sel == SEL_MASKED);
    en_set_we   = bus_wr && (sel == SEL_EN_SET);
    en_clr_we   = bus_wr && (sel == SEL_EN_CLR);
    eoi_we      = bus_wr && (sel == SEL_EOI);
  end

  always_comb begin
    case (sel)
      SEL_RAW:    rd_bits = raw_stat;
      SEL_MASKED: rd_bits = masked_stat;
      SEL_EN_SET,
      SEL_EN_CLR: rd_bits = en_mask;
      default:    rd_bits = '0;
    endcase
  end

  assign bus_rdata = {{PAD_W{1'b0}}, rd_bits};

endmodule

// File: rtl/disp_evt_status.sv
module disp_evt_status
  import disp_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_we,
  input  logic [STAT_W-1:0]  clr_bits,
  output logic [STAT_W-1:0]  raw_q
);

  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;

  // Scatter the event pulses onto their status positions.
  always_comb begin
    set_vec = '0;
    for (int unsigned i = 0; i < NUM_EVT; i++) begin
      set_vec[evt_bit(i)] = evt_i[i];
    end
  end

  assign clr_vec = clr_we ? clr_bits : '0;

  // A new pulse takes priority over a clear aimed at the same bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= ((raw_q & ~clr_vec) | set_vec) & impl_mask();
  end

endmodule

// File: rtl/disp_evt_enable.sv
module disp_evt_enable
  import disp_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] wbits,
  output logic [STAT_W-1:0] en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (set_we) en_q <= en_q | (wbits & impl_mask());
    else if (clr_we) en_q <= en_q & ~wbits;
  end

endmodule

// File: rtl/disp_evt_irqgen.sv
module disp_evt_irqgen
  import disp_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] raw_stat,
  input  logic [STAT_W-1:0] en_mask,
  input  logic              eoi_we,
  output logic [STAT_W-1:0] masked_stat,
  output logic              irq_o
);

  logic eoi_hold_q;

  assign masked_stat = raw_stat & en_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eoi_hold_q <= 1'b0;
    else        eoi_hold_q <= eoi_we;
  end

  assign irq_o = (|masked_stat) && !eoi_hold_q;

endmodule

// File: rtl/disp_evt_irq.sv
module disp_evt_irq
  import disp_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFF_RAW    = 8'h58,
  parameter logic [ADDR_W-1:0] OFF_MASKED = 8'h5C,
  parameter logic [ADDR_W-1:0] OFF_EN_SET = 8'h60,
  parameter logic [ADDR_W-1:0] OFF_EN_CLR = 8'h64,
  parameter logic [ADDR_W-1:0] OFF_EOI    = 8'h68
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);

  logic [STAT_W-1:0] raw_stat;
  logic [STAT_W-1:0] en_mask;
  logic [STAT_W-1:0] masked_stat;
  logic              stat_clr_we;
  logic              en_set_we;
  logic              en_clr_we;
  logic              eoi_we;
  logic [STAT_W-1:0] wbits;

  assign wbits = bus_wdata[STAT_W-1:0];

  disp_evt_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .OFF_RAW   (OFF_RAW),
    .OFF_MASKED(OFF_MASKED),
    .OFF_EN_SET(OFF_EN_SET),
    .OFF_EN_CLR(OFF_EN_CLR),
    .OFF_EOI   (OFF_EOI)
  ) u_decode (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .raw_stat   (raw_stat),
    .masked_stat(masked_stat),
    .en_mask    (en_mask),
    .stat_clr_we(stat_clr_we),
    .en_set_we  (en_set_we),
    .en_clr_we  (en_clr_we),
    .eoi_we     (eoi_we),
    .bus_rdata  (bus_rdata)
  );

  disp_evt_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .clr_we  (stat_clr_we),
    .clr_bits(wbits),
    .raw_q   (raw_stat)
  );

  disp_evt_enable u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .set_we(en_set_we),
    .clr_we(en_clr_we),
    .wbits (wbits),
    .en_q  (en_mask)
  );

  disp_evt_irqgen u_irqgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_stat   (raw_stat),
    .en_mask    (en_mask),
    .eoi_we     (eoi_we),
    .masked_stat(masked_stat),
    .irq_o      (irq_o)
  );

endmodule

// File: rtl/disp_evt_irq_chk.sv
module disp_evt_irq_chk
  import disp_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFF_RAW    = 8'h58,
  parameter logic [ADDR_W-1:0] OFF_MASKED = 8'h5C,
  parameter logic [ADDR_W-1:0] OFF_EN_SET = 8'h60,
  parameter logic [ADDR_W-1:0] OFF_EN_CLR = 8'h64,
  parameter logic [ADDR_W-1:0] OFF_EOI    = 8'h68
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_o,
  input logic [STAT_W-1:0]  raw,
  input logic [STAT_W-1:0]  en
);

  localparam logic [STAT_W-1:0] IMPL = impl_mask();

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    localparam int unsigned P = evt_bit(g);

    // R2 and R4: a pulse always leaves its bit set
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> raw[P]);

    // R3: a clearing write without a concurrent pulse clears the bit
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == OFF_RAW || bus_addr == OFF_MASKED)
       && bus_wdata[P] && !evt_i[g]) |=> !raw[P]);

    // R5: enable set and clear
    p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFF_EN_SET && bus_wdata[P]) |=> en[P]);
    p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFF_EN_CLR && bus_wdata[P]) |=> !en[P]);
  end

  // R6: masked read view
  p_masked_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_MASKED) |-> (bus_rdata[STAT_W-1:0] == (raw & en)));

  // R7: no interrupt without an enabled pending event
  p_irq_needs_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((raw & en) != '0));

  // R7: interrupt present when pending and not held
  p_irq_when_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((raw & en) != '0) && !($past(bus_wr) && $past(bus_addr) == OFF_EOI))
      |-> irq_o);

  // R8: end-of-interrupt drops the line for the next cycle
  p_eoi_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_EOI) |=> !irq_o);

  // R9: unimplemented bits stay zero
  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~IMPL) == '0) && ((en & ~IMPL) == '0));

endmodule

bind disp_evt_irq disp_evt_irq_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .OFF_RAW   (OFF_RAW),
  .OFF_MASKED(OFF_MASKED),
  .OFF_EN_SET(OFF_EN_SET),
  .OFF_EN_CLR(OFF_EN_CLR),
  .OFF_EOI   (OFF_EOI)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_i    (evt_i),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_o    (irq_o),
  .raw      (raw_stat),
  .en       (en_mask)
);

// File: tb/disp_evt_irq_tb_top.sv
module disp_evt_irq_tb_top;

  localparam logic [7:0] A_RAW  = 8'h58;
  localparam logic [7:0] A_MSK  = 8'h5C;
  localparam logic [7:0] A_ESET = 8'h60;
  localparam logic [7:0] A_ECLR = 8'h64;
  localparam logic [7:0] A_EOI  = 8'h68;

  logic        clk;
  logic        rst_n;
  logic [5:0]  evt_i;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  int pos [6] = '{0, 2, 5, 6, 8, 9};

  disp_evt_irq dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // All tasks are entered on a falling edge and leave on a falling edge.
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [5:0] m);
    evt_i = m;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(A_RAW, d);  check("R1", "raw after reset", d, 0);
    bus_read(A_MSK, d);  check("R1", "masked after reset", d, 0);
    bus_read(A_ESET, d); check("R1", "enable after reset", d, 0);
    check("R1", "irq after reset", {31'd0, irq_o}, 0);
  endtask

  task automatic t_event_map;
    logic [31:0] d;
    for (int i = 0; i < 6; i++) begin
      pulse(6'(1 << i));
      bus_read(A_RAW, d);
      check("R2", $sformatf("event %0d position", i), d, 32'(1 << pos[i]));
      @(negedge clk);
      bus_read(A_RAW, d);
      check("R2", $sformatf("event %0d sticky", i), d, 32'(1 << pos[i]));
      bus_write(A_RAW, d);
      bus_read(A_RAW, d);
      check("R3", $sformatf("event %0d write-back ack", i), d, 0);
    end
  endtask

  task automatic t_w1c_partial;
    logic [31:0] d;
    pulse(6'h3F);
    bus_read(A_RAW, d);  check("R2", "all events", d, 32'h365);
    bus_write(A_RAW, 32'h0000_0021);
    bus_read(A_RAW, d);  check("R3", "partial clear raw offset", d, 32'h344);
    bus_write(A_MSK, 32'h0000_0300);
    bus_read(A_RAW, d);  check("R3", "clear via masked offset", d, 32'h044);
    bus_write(A_RAW, 32'hFFFF_FFFF);
    bus_read(A_RAW, d);  check("R3", "clear all", d, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    pulse(6'h01);
    evt_i = 6'h10;
    bus_write(A_RAW, 32'h0000_0101);
    evt_i = '0;
    bus_read(A_RAW, d);  check("R4", "pulse beats clear", d, 32'h100);
    bus_write(A_RAW, 32'h0000_0100);
    bus_read(A_RAW, d);  check("R4", "bit clears afterwards", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    pulse(6'h0C);
    bus_write(A_ESET, 32'hFFFF_FFFF);
    bus_read(A_ESET, d); check("R5", "enable via set offset", d, 32'h365);
    bus_read(A_ECLR, d); check("R5", "enable via clear offset", d, 32'h365);
    bus_write(A_ECLR, 32'h0000_0060);
    bus_read(A_ESET, d); check("R5", "enable after clear", d, 32'h305);
    bus_write(A_ESET, 32'h0000_0020);
    bus_read(A_ECLR, d); check("R5", "set ORs in", d, 32'h325);
    bus_read(A_RAW, d);  check("R6", "raw view", d, 32'h060);
    bus_read(A_MSK, d);  check("R6", "masked view", d, 32'h020);
    bus_write(A_ECLR, 32'hFFFF_FFFF);
    bus_write(A_RAW, 32'hFFFF_FFFF);
    bus_read(A_ESET, d); check("R5", "enable cleared", d, 0);
  endtask

  task automatic t_irq;
    bus_write(A_ESET, 32'h0000_0100);
    check("R7", "idle irq", {31'd0, irq_o}, 0);
    pulse(6'h20);
    check("R7", "disabled event no irq", {31'd0, irq_o}, 0);
    pulse(6'h10);
    check("R7", "enabled event irq", {31'd0, irq_o}, 1);
    bus_write(A_EOI, 32'h0);
    check("R8", "irq dropped after eoi", {31'd0, irq_o}, 0);
    @(negedge clk);
    check("R8", "irq returns while pending", {31'd0, irq_o}, 1);
    bus_write(A_RAW, 32'h0000_0100);
    check("R7", "irq low after ack", {31'd0, irq_o}, 0);
    bus_write(A_EOI, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R8", "no reassert when clear", {31'd0, irq_o}, 0);
    bus_write(A_RAW, 32'hFFFF_FFFF);
    bus_write(A_ECLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    pulse(6'h02);
    bus_write(A_ESET, 32'h0000_0004);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h6C, 32'hFFFF_FFFF);
    bus_write(8'h54, 32'hFFFF_FFFF);
    bus_read(A_RAW, d);  check("R9", "raw untouched by stray writes", d, 32'h004);
    bus_read(A_ESET, d); check("R9", "enable untouched", d, 32'h004);
    bus_read(8'h6C, d);  check("R9", "unmapped read", d, 0);
    bus_read(A_EOI, d);  check("R9", "eoi offset reads zero", d, 0);
    bus_write(A_ECLR, 32'hFFFF_FFFF);
    bus_write(A_ESET, 32'hFFFF_FC9A);
    bus_read(A_ESET, d); check("R9", "unimplemented enable bits", d, 0);
    bus_write(A_RAW, 32'hFFFF_FFFF);
  endtask

  initial begin
    rst_n     = 1'b0;
    evt_i     = '0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_event_map();
    t_w1c_partial();
    t_set_wins();
    t_enable();
    t_irq();
    t_unmapped();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule